// File: doc/BRIEF.md
# SPI Transmit Frame Queue

This block holds outgoing SPI frames between a register-write port and the shift register of an SPI serializer. Software places 16-bit frames into a four-entry queue with a single-cycle write strobe. When the serializer begins a transfer, it pulses a start input. If the queue holds data, the oldest frame is moved into the shift-data output, and the entry count drops by one. The queue keeps its own entry count and raises full and empty indications.

Two sticky status bits report events. A completion bit is set at the end of every frame. An underflow bit is set when the block is a slave and an external master starts a transfer while the queue is empty. In that case the shift register is loaded with zeros, so the slave still drives defined data. Each status bit is cleared by writing a one to its position in a clear vector. A flush input empties the queue in one cycle.

A write to a full queue is dropped silently. The stored frames and the count stay the same, and no status bit changes.

Top module: `spi_txq`

## Requirements
- R1: After a synchronous reset, `count` is 0, `empty` is 1, `full` is 0, `shift_load` is 0, and both status bits are 0.
- R2: A cycle with `wr_en` high, no flush and `count` below 4 stores `wr_data` and raises `count` by one on the next edge. `full` is 1 exactly when `count` is 4.
- R3: A write while `count` is 4 is dropped. `count` stays at 4, the four stored frames come out unchanged, and neither status bit changes.
- R4: A `xfer_start` pulse while the queue holds data gives `shift_load` high for one cycle on the next edge. In that cycle `shift_data` holds the oldest stored frame, and `count` has dropped by one.
- R5: Frames leave in the order they were written, also after the storage indices have wrapped past the last entry.
- R6: A `xfer_done` pulse sets `done_flag`. The flag stays set until a cycle with `flag_clr[0]` high. If `xfer_done` and `flag_clr[0]` arrive in the same cycle, the flag stays set.
- R7: A `xfer_start` pulse with `slave_mode` high and an empty queue does three things on the next edge: it sets `ufl_flag`, it raises `shift_load`, and it makes `shift_data` zero. `ufl_flag` stays set until a cycle with `flag_clr[1]` high, and a set in that same cycle wins.
- R8: A `xfer_start` pulse with `slave_mode` low and an empty queue leaves `shift_load` low, `ufl_flag` unchanged and `count` at 0.
- R9: A cycle with `flush` high empties the queue, so `count` is 0 on the next edge. A write in the same cycle is discarded. A `xfer_start` in the same cycle is handled as if the queue were empty.
- R10: A write and a `xfer_start` in the same cycle, with `count` between 1 and 3, leave `count` unchanged and keep the frame order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one frame |
| wr_data | input | 16 | Frame to store |
| flush | input | 1 | Empties the queue (write-one control) |
| slave_mode | input | 1 | 1 when the block is an SPI slave |
| xfer_start | input | 1 | Serializer starts a transfer and takes a frame |
| xfer_done | input | 1 | Serializer has finished shifting a frame |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 clears completion, bit 1 clears underflow |
| shift_load | output | 1 | One-cycle pulse: `shift_data` is valid for the shift register |
| shift_data | output | 16 | Frame handed to the shift register (zero on underflow) |
| count | output | 3 | Number of stored frames, 0 to 4 |
| full | output | 1 | Queue holds 4 frames |
| empty | output | 1 | Queue holds no frames |
| done_flag | output | 1 | Sticky transfer-complete status |
| ufl_flag | output | 1 | Sticky transmit-underflow status |

## Verification
The bench covers several failure modes:
- A write to a full queue. A design that let this write through would push `count` to 5, or it would overwrite the oldest frame. The drain that follows would then show a wrong frame.
- A write followed by reads that run the indices past the last slot. This would expose a design with broken index wrap or out-of-order reads.
- A write in the flush cycle, followed by a slave start. If the flush did not discard the write, the start would load real data instead of zeros and would not flag underflow.
- A set and a clear on the same flag in one cycle. A design where the clear wins would drop either status bit.
- A start in master mode on an empty queue. A design that does not check the mode would load zeros and raise a false underflow.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
  // Positions inside the write-one-to-clear vector
  localparam int FLG_DONE = 0;
  localparam int FLG_UFL  = 1;
  localparam int FLG_N    = 2;

  // What the queue does with a transfer start in a given cycle
  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_POP  = 2'd1,
    ST_ZERO = 2'd2
  } start_act_e;
endpackage

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import spi_txq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          flush,
  input  logic          slave_mode,
  input  logic          xfer_start,
  output logic          we,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output start_act_e    act,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic empty_eff;
  logic do_pop;

  // A flush makes the queue look empty for this cycle
  assign empty_eff = flush || (count == '0);
  assign we        = wr_en && !flush && (count != CNT_MAX);
  assign do_pop    = xfer_start && !empty_eff;

  always_comb begin
    if (do_pop)                                act = ST_POP;
    else if (xfer_start && slave_mode)         act = ST_ZERO;
    else                                       act = ST_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (we)     wr_ptr <= wr_ptr + AW'(1);
      if (do_pop) rd_ptr <= rd_ptr + AW'(1);
      case ({we, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == CNT_MAX);
  assign empty = (count == '0);
endmodule

// File: rtl/txq_store.sv
module txq_store
  import spi_txq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  input  start_act_e        act,
  output logic              shift_load,
  output logic [DATA_W-1:0] shift_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Plain write port, no reset, so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_load <= 1'b0;
      shift_data <= '0;
    end else begin
      shift_load <= (act != ST_NONE);
      if (act == ST_POP)       shift_data <= mem[raddr];
      else if (act == ST_ZERO) shift_data <= '0;
    end
  end
endmodule

// File: rtl/txq_flags.sv
module txq_flags
  import spi_txq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [FLG_N-1:0] set_evt,
  input  logic [FLG_N-1:0] clr,
  output logic [FLG_N-1:0] flags
);
  for (genvar i = 0; i < FLG_N; i++) begin : g_flag
    // Set has priority over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_evt[i]) flags[i] <= 1'b1;
      else if (clr[i])     flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_txq.sv
module spi_txq
  import spi_txq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flush,
  input  logic              slave_mode,
  input  logic              xfer_start,
  input  logic              xfer_done,
  input  logic [FLG_N-1:0]  flag_clr,
  output logic              shift_load,
  output logic [DATA_W-1:0] shift_data,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty,
  output logic              done_flag,
  output logic              ufl_flag
);
  logic          we;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  start_act_e    act;
  logic [FLG_N-1:0] set_evt;
  logic [FLG_N-1:0] flags;

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .flush(flush),
    .slave_mode(slave_mode), .xfer_start(xfer_start),
    .we(we), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .act(act),
    .count(count), .full(full), .empty(empty)
  );

  txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(we), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .act(act),
    .shift_load(shift_load), .shift_data(shift_data)
  );

  always_comb begin
    set_evt           = '0;
    set_evt[FLG_DONE] = xfer_done;
    set_evt[FLG_UFL]  = (act == ST_ZERO);
  end

  txq_flags u_flags (
    .clk(clk), .rst(rst), .set_evt(set_evt), .clr(flag_clr), .flags(flags)
  );

  assign done_flag = flags[FLG_DONE];
  assign ufl_flag  = flags[FLG_UFL];
endmodule

// File: rtl/spi_txq_chk.sv
module spi_txq_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              flush,
  input logic              slave_mode,
  input logic              xfer_start,
  input logic              xfer_done,
  input logic [1:0]        flag_clr,
  input logic              shift_load,
  input logic [DATA_W-1:0] shift_data,
  input logic [CW-1:0]     count,
  input logic              full,
  input logic              empty,
  input logic              done_flag,
  input logic              ufl_flag
);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= CMAX); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    full && wr_en && !xfer_start && !flush |=> count == CMAX && $stable(ufl_flag)); // R3

  AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
    xfer_start && !empty && !wr_en && !flush |=> shift_load && count == $past(count) - CW'(1)); // R4

  AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> done_flag); // R6

  AST_UFL_ZERO: assert property (@(posedge clk) disable iff (rst)
    xfer_start && slave_mode && (empty || flush) |=> shift_load && shift_data == '0 && ufl_flag); // R7

  AST_MASTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    xfer_start && !slave_mode && (empty || flush) && !flag_clr[1] |=> !shift_load && $stable(ufl_flag)); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0 && empty); // R9
endmodule

bind spi_txq spi_txq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .flush(flush),
  .slave_mode(slave_mode), .xfer_start(xfer_start), .xfer_done(xfer_done),
  .flag_clr(flag_clr), .shift_load(shift_load), .shift_data(shift_data),
  .count(count), .full(full), .empty(empty),
  .done_flag(done_flag), .ufl_flag(ufl_flag)
);

// File: tb/spi_txq_tb.sv
module spi_txq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        flush;
  logic        slave_mode;
  logic        xfer_start;
  logic        xfer_done;
  logic [1:0]  flag_clr;
  logic        shift_load;
  logic [15:0] shift_data;
  logic [2:0]  count;
  logic        full;
  logic        empty;
  logic        done_flag;
  logic        ufl_flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_txq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
    .slave_mode(slave_mode), .xfer_start(xfer_start), .xfer_done(xfer_done),
    .flag_clr(flag_clr), .shift_load(shift_load), .shift_data(shift_data),
    .count(count), .full(full), .empty(empty),
    .done_flag(done_flag), .ufl_flag(ufl_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = '0; flush = 0; xfer_start = 0; xfer_done = 0; flag_clr = '0;
  endtask

  // Inputs were set at a falling edge; pass one rising edge, stop at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] d);
    wr_en = 1; wr_data = d; step(); idle_inputs();
  endtask

  task automatic pop_expect(input logic [15:0] d, input string req);
    xfer_start = 1; step();
    check(shift_load == 1'b1, req, shift_load, 1);
    check(shift_data == d, req, shift_data, d);
    idle_inputs();
  endtask

  task automatic t_reset();
    rst = 1; idle_inputs(); slave_mode = 0;
    step(); step(); rst = 0;
    check(count == 0 && empty && !full, "R1", {full, empty, count}, 3'b0);
    check(!shift_load && !done_flag && !ufl_flag, "R1", {shift_load, done_flag, ufl_flag}, 0);
  endtask

  task automatic t_fill_and_drop();
    logic [15:0] v [4] = '{16'hA001, 16'hB002, 16'hC003, 16'hD004};
    for (int i = 0; i < 4; i++) begin
      push(v[i]);
      check(count == 3'(i + 1), "R2", count, i + 1);
    end
    check(full == 1'b1, "R2", full, 1);
    push(16'hEEEE);
    check(count == 3'd4, "R3", count, 4);
    check(!done_flag && !ufl_flag, "R3", {done_flag, ufl_flag}, 0);
    for (int i = 0; i < 4; i++) begin
      pop_expect(v[i], "R3");
      check(count == 3'(3 - i), "R4", count, 3 - i);
    end
    check(empty == 1'b1, "R4", empty, 1);
  endtask

  task automatic t_wrap_and_concurrent();
    push(16'h1111); push(16'h2222); push(16'h3333);
    pop_expect(16'h1111, "R5");
    pop_expect(16'h2222, "R5");
    push(16'h4444); push(16'h5555);
    // count is 3; write and start together
    wr_en = 1; wr_data = 16'h6666; xfer_start = 1; step();
    check(shift_data == 16'h3333, "R10", shift_data, 16'h3333);
    check(count == 3'd3, "R10", count, 3);
    idle_inputs();
    pop_expect(16'h4444, "R5");
    pop_expect(16'h5555, "R5");
    pop_expect(16'h6666, "R10");
    check(count == 3'd0, "R5", count, 0);
  endtask

  task automatic t_done_flag();
    xfer_done = 1; step(); idle_inputs();
    check(done_flag == 1'b1, "R6", done_flag, 1);
    step(); step();
    check(done_flag == 1'b1, "R6", done_flag, 1);
    flag_clr = 2'b10; step(); idle_inputs();
    check(done_flag == 1'b1, "R6", done_flag, 1);
    xfer_done = 1; flag_clr = 2'b01; step(); idle_inputs();
    check(done_flag == 1'b1, "R6", done_flag, 1);
    flag_clr = 2'b01; step(); idle_inputs();
    check(done_flag == 1'b0, "R6", done_flag, 0);
  endtask

  task automatic t_underflow();
    slave_mode = 1;
    pop_expect(16'h0000, "R7");
    check(ufl_flag == 1'b1 && count == 3'd0, "R7", {ufl_flag, count}, 4'b1000);
    xfer_start = 1; flag_clr = 2'b10; step(); idle_inputs();
    check(ufl_flag == 1'b1, "R7", ufl_flag, 1);
    flag_clr = 2'b10; step(); idle_inputs();
    check(ufl_flag == 1'b0, "R7", ufl_flag, 0);
    slave_mode = 0;
  endtask

  task automatic t_master_empty();
    slave_mode = 0;
    xfer_start = 1; step(); idle_inputs();
    check(shift_load == 1'b0, "R8", shift_load, 0);
    check(ufl_flag == 1'b0 && count == 3'd0, "R8", {ufl_flag, count}, 0);
  endtask

  task automatic t_flush();
    push(16'h7777); push(16'h8888);
    flush = 1; wr_en = 1; wr_data = 16'h9999; step(); idle_inputs();
    check(count == 3'd0 && empty, "R9", count, 0);
    slave_mode = 1;
    pop_expect(16'h0000, "R9");
    check(ufl_flag == 1'b1, "R9", ufl_flag, 1);
    flag_clr = 2'b10; step(); idle_inputs();
    push(16'hAAAA);
    flush = 1; xfer_start = 1; step();
    check(shift_data == 16'h0000 && shift_load, "R9", shift_data, 0);
    check(count == 3'd0, "R9", count, 0);
    idle_inputs(); slave_mode = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_and_drop();
    t_wrap_and_concurrent();
    t_done_flag();
    t_underflow();
    t_master_empty();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule